// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter. Software writes a channel number into a channel register. A start request then copies that number onto the input multiplexer select and runs a sample phase of `SAMPLE_CYCLES` clocks. After the sample phase, the block holds the sampled voltage for the rest of the conversion.

During hold, the block runs a binary search from the most significant bit down. It drives a trial code to an external resistor-string tap selector and reads back one comparator bit, which is high when the held input is at or above the tap voltage. When the last bit is decided, the code is copied into a result register and a one-cycle end-of-conversion interrupt is raised. A status flag records whether the conversion was started while the converter enable was low; the result of such a conversion is not to be trusted.

The multiplexer, sample-and-hold, resistor string and comparator are analog parts and sit outside the block.

Top module: `sar_adc_seq`

## Requirements
- R1: `muxSel` takes the channel register value on the start edge. A channel write during a conversion leaves `muxSel` unchanged until the next start.
- R2: `sampleOn` is high for exactly `SAMPLE_CYCLES` cycles following the start edge. `holdOn` is then high until the result is latched. The two are never high together.
- R3: The first trial code on `tapCode` is 8'h80 (bit 7 set).
- R4: A trial bit stays 1 when `cmpHigh` is 1 (input at or above the tap) and is cleared otherwise. The next trial code is the current code with the next lower bit set, so the second code is 8'hC0 if bit 7 was kept and 8'h40 if it was cleared.
- R5: Each of the eight trials takes two cycles (tap settle, then decide). The result is therefore latched `SAMPLE_CYCLES`+16 clock edges after the start edge, and it equals the held input code.
- R6: `result` holds its value until the next conversion completes.
- R7: `eocIrq` is a one-cycle pulse on the same edge `result` is loaded. `busy` is high from the start edge until that edge.
- R8: A start request while `busy` is high is ignored: no restart, and no extra interrupt.
- R9: `firstInvalid` is set on a start taken with `convEn` low. It is cleared on a start taken with `convEn` high.
- R10: After reset, `busy`, `sampleOn`, `holdOn`, `eocIrq`, `firstInvalid`, `result`, `tapCode` and `muxSel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chanWe | input | 1 | Write strobe for the channel register |
| chanIn | input | CHAN_W | Channel number to write |
| convEn | input | 1 | Converter (comparator) enable |
| startReq | input | 1 | Conversion start request |
| cmpHigh | input | 1 | Comparator: 1 when held input >= tap voltage |
| muxSel | output | CHAN_W | Input multiplexer select |
| sampleOn | output | 1 | Sample-and-hold in sample mode |
| holdOn | output | 1 | Sample-and-hold in hold mode |
| tapCode | output | RES_W | Trial code to resistor-string tap selector |
| busy | output | 1 | Conversion in progress |
| result | output | RES_W | Latched conversion result |
| eocIrq | output | 1 | End-of-conversion interrupt pulse |
| firstInvalid | output | 1 | Last start was taken with the enable low |

## Verification
If the start request is sampled on edge E0, then `busy`, `muxSel`, `sampleOn` and `firstInvalid` change at E0. `holdOn` rises together with the first tap code at E`SAMPLE_CYCLES`. The second tap appears two edges later. `result` and `eocIrq` change at E`SAMPLE_CYCLES`+16. The bench drives and samples on falling edges and counts falling edges from the start edge, so each check reads a value in the half cycle after the edge that must have produced it. It also checks the edge just before the result is due, to show the result is neither early nor late.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef struct packed {
    logic loadMux;   // start taken: copy channel, record enable state
    logic initSar;   // sample phase over: load first trial
    logic decide;    // apply comparator to current trial bit
    logic latchRes;  // last decision: copy code to result
  } sarStrobe_t;
endpackage

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 4,
  parameter int RES_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  output sarStrobe_t strb,
  output logic       sampleOn,
  output logic       holdOn,
  output logic       busy
);
  localparam int CNT_W = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam int BIT_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(SAMPLE_CYCLES - 1);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(RES_W - 1);

  typedef enum logic [1:0] {IDLE, SAMPLE, SETTLE, DECIDE} seqState_t;

  seqState_t state, stateNext;
  logic [CNT_W-1:0] sampleCnt;
  logic [BIT_W-1:0] bitCnt;

  always_comb begin
    strb = '0;
    stateNext = state;
    unique case (state)
      IDLE: if (startReq) begin
        strb.loadMux = 1'b1;
        stateNext = SAMPLE;
      end
      SAMPLE: if (sampleCnt == LAST_SAMPLE) begin
        strb.initSar = 1'b1;
        stateNext = SETTLE;
      end
      SETTLE: stateNext = DECIDE;
      DECIDE: begin
        strb.decide = 1'b1;
        if (bitCnt == '0) begin
          strb.latchRes = 1'b1;
          stateNext = IDLE;
        end else begin
          stateNext = SETTLE;
        end
      end
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      sampleCnt <= '0;
      bitCnt    <= '0;
    end else begin
      state <= stateNext;
      if (strb.loadMux)       sampleCnt <= '0;
      else if (state == SAMPLE) sampleCnt <= sampleCnt + 1'b1;
      if (strb.initSar)       bitCnt <= TOP_BIT;
      else if (strb.decide && bitCnt != '0) bitCnt <= bitCnt - 1'b1;
    end
  end

  assign sampleOn = (state == SAMPLE);
  assign holdOn   = (state == SETTLE) || (state == DECIDE);
  assign busy     = (state != IDLE);
endmodule

// File: rtl/sar_adc_dp.sv
module sar_adc_dp
  import sar_adc_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int RES_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sarStrobe_t        strb,
  input  logic              chanWe,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic              convEn,
  input  logic              cmpHigh,
  output logic [CHAN_W-1:0] muxSel,
  output logic [RES_W-1:0]  tapCode,
  output logic [RES_W-1:0]  result,
  output logic              eocIrq,
  output logic              firstInvalid
);
  localparam logic [RES_W-1:0] TOP_MASK = {1'b1, {(RES_W-1){1'b0}}};

  logic [CHAN_W-1:0] chanReg;
  logic [RES_W-1:0]  sarReg, trialMask, decided;

  // current trial bit kept on comparator high, cleared otherwise
  assign decided = cmpHigh ? sarReg : (sarReg & ~trialMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chanReg      <= '0;
      muxSel       <= '0;
      sarReg       <= '0;
      trialMask    <= '0;
      result       <= '0;
      eocIrq       <= 1'b0;
      firstInvalid <= 1'b0;
    end else begin
      if (chanWe) chanReg <= chanIn;
      if (strb.loadMux) begin
        muxSel       <= chanReg;
        firstInvalid <= ~convEn;
      end
      if (strb.initSar) begin
        sarReg    <= TOP_MASK;
        trialMask <= TOP_MASK;
      end else if (strb.decide) begin
        sarReg    <= decided | (trialMask >> 1);
        trialMask <= trialMask >> 1;
      end
      if (strb.latchRes) result <= decided;
      eocIrq <= strb.latchRes;
    end
  end

  assign tapCode = sarReg;
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int RES_W = 8,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chanWe,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic              convEn,
  input  logic              startReq,
  input  logic              cmpHigh,
  output logic [CHAN_W-1:0] muxSel,
  output logic              sampleOn,
  output logic              holdOn,
  output logic [RES_W-1:0]  tapCode,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              eocIrq,
  output logic              firstInvalid
);
  sarStrobe_t strb;

  sar_adc_ctrl #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .RES_W(RES_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .strb(strb),
    .sampleOn(sampleOn), .holdOn(holdOn), .busy(busy)
  );

  sar_adc_dp #(.CHAN_W(CHAN_W), .RES_W(RES_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .chanWe(chanWe), .chanIn(chanIn),
    .convEn(convEn), .cmpHigh(cmpHigh), .muxSel(muxSel), .tapCode(tapCode),
    .result(result), .eocIrq(eocIrq), .firstInvalid(firstInvalid)
  );
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int CHAN_W = 3,
  parameter int RES_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sampleOn,
  input logic              holdOn,
  input logic              busy,
  input logic              eocIrq,
  input logic [RES_W-1:0]  tapCode,
  input logic [RES_W-1:0]  result,
  input logic [CHAN_W-1:0] muxSel
);
  localparam logic [RES_W-1:0] HALF = {1'b1, {(RES_W-1){1'b0}}};

  // R2
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampleOn && holdOn));
  // R1
  a_r1_mux_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(muxSel));
  // R3
  a_r3_first_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdOn) |-> (tapCode == HALF));
  // R7
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eocIrq |=> !eocIrq);
  a_r7_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eocIrq |-> $fell(busy));
  // R6
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !eocIrq |-> $stable(result));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.CHAN_W(CHAN_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sampleOn(sampleOn), .holdOn(holdOn),
  .busy(busy), .eocIrq(eocIrq), .tapCode(tapCode), .result(result),
  .muxSel(muxSel)
);

// File: tb/sar_adc_seq_tb_top.sv
module sar_adc_seq_tb_top;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chanWe = 1'b0;
  logic [2:0] chanIn = '0;
  logic convEn = 1'b1;
  logic startReq = 1'b0;
  logic cmpHigh;
  logic [2:0] muxSel;
  logic sampleOn, holdOn, busy, eocIrq, firstInvalid;
  logic [7:0] tapCode, result;

  int testCnt = 0;
  int failCnt = 0;
  int eocCount = 0;
  bit finished = 0;

  logic [7:0] chanVolt [8];
  logic [7:0] heldV = '0;

  always #10 clk = ~clk;

  // analog models: sample-and-hold tracks while sampling, comparator on held value
  always @(negedge clk) if (sampleOn) heldV <= chanVolt[muxSel];
  assign cmpHigh = (heldV >= tapCode);
  always @(negedge clk) if (eocIrq) eocCount++;

  sar_adc_seq #(.CHAN_W(3), .RES_W(8), .SAMPLE_CYCLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .chanWe(chanWe), .chanIn(chanIn),
    .convEn(convEn), .startReq(startReq), .cmpHigh(cmpHigh), .muxSel(muxSel),
    .sampleOn(sampleOn), .holdOn(holdOn), .tapCode(tapCode), .busy(busy),
    .result(result), .eocIrq(eocIrq), .firstInvalid(firstInvalid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {channel, voltage code}
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'h00}, {3'd7, 8'hFF}, {3'd3, 8'h80},
    {3'd5, 8'h7F}, {3'd1, 8'h01}, {3'd6, 8'hA5}
  };

  task automatic runConv(input logic [2:0] ch, input logic [7:0] v, input logic en);
    chanVolt[ch] = v;
    @(negedge clk); chanWe = 1'b1; chanIn = ch; convEn = en;
    @(negedge clk); chanWe = 1'b0; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;                       // after E0
    chk(busy === 1'b1, "R7 busy at start", busy, 1);
    chk(muxSel === ch, "R1 muxSel loaded", muxSel, ch);
    repeat (S-1) @(negedge clk);                           // after E(S-1)
    chk(sampleOn === 1'b1 && holdOn === 1'b0, "R2 last sample cycle", {sampleOn, holdOn}, 2);
    @(negedge clk);                                        // after E(S)
    chk(holdOn === 1'b1 && sampleOn === 1'b0, "R2 hold entered", {sampleOn, holdOn}, 1);
    chk(tapCode === 8'h80, "R3 first tap", tapCode, 8'h80);
    repeat (2) @(negedge clk);                             // after E(S+2)
    chk(tapCode === (v[7] ? 8'hC0 : 8'h40), "R4 second tap", tapCode, v[7] ? 8'hC0 : 8'h40);
    repeat (13) @(negedge clk);                            // after E(S+15)
    chk(eocIrq === 1'b0 && busy === 1'b1, "R5 not done early", {busy, eocIrq}, 2);
    @(negedge clk);                                        // after E(S+16)
    chk(eocIrq === 1'b1 && busy === 1'b0 && holdOn === 1'b0, "R7 done edge",
        {busy, holdOn, eocIrq}, 1);
    chk(result === v, "R5 result", result, v);
    @(negedge clk);
    chk(eocIrq === 1'b0, "R7 single pulse", eocIrq, 0);
    chk(result === v, "R6 result held", result, v);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) chanVolt[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, sampleOn, holdOn, eocIrq, firstInvalid} === 5'b0, "R10 reset flags",
        {busy, sampleOn, holdOn, eocIrq, firstInvalid}, 0);
    chk(result === 8'h0 && tapCode === 8'h0 && muxSel === 3'h0, "R10 reset data",
        {result, tapCode}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) runConv(VEC[k][10:8], VEC[k][7:0], 1'b1);

    // R8 start ignored while busy; R1 channel write mid-conversion ignored
    chanVolt[2] = 8'h5A;
    chanVolt[4] = 8'hE0;
    @(negedge clk); chanWe = 1'b1; chanIn = 3'd2;
    @(negedge clk); chanWe = 1'b0; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;                       // after E0
    eocCount = 0;
    repeat (3) @(negedge clk);
    startReq = 1'b1; chanWe = 1'b1; chanIn = 3'd4;
    @(negedge clk); startReq = 1'b0; chanWe = 1'b0;        // after E4
    chk(muxSel === 3'd2, "R1 muxSel unchanged mid-conversion", muxSel, 2);
    repeat (S + 11) @(negedge clk);                        // after E(S+15)
    chk(eocIrq === 1'b0 && busy === 1'b1, "R8 no restart", {busy, eocIrq}, 2);
    @(negedge clk);                                        // after E(S+16)
    chk(eocIrq === 1'b1 && result === 8'h5A, "R8 original conversion completes", result, 8'h5A);
    repeat (30) @(negedge clk);
    chk(eocCount == 1, "R8 single interrupt", eocCount, 1);
    chk(busy === 1'b0, "R8 idle after", busy, 0);

    // next start picks up the channel written during the previous conversion
    runConv(3'd4, 8'hE0, 1'b1);

    // R9 invalid flag
    runConv(3'd3, 8'h33, 1'b0);
    chk(firstInvalid === 1'b1, "R9 flag set on start with enable low", firstInvalid, 1);
    runConv(3'd3, 8'h34, 1'b1);
    chk(firstInvalid === 1'b0, "R9 flag cleared on start with enable high", firstInvalid, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule